// File: doc/BRIEF.md
# External Interrupt Sense and Latch Unit

This block sits between the raw external interrupt pins and the priority controller. It brings every pin into the system clock domain through a two-stage synchroniser. It then decides, line by line, whether the pin is asking for service, and keeps that request as a pending flag until the flag is serviced. There are four source classes. The first is a single non-maskable line with a selectable edge. The second is sixteen general request lines, each with a selectable edge or level sense. The third is sixteen keypad lines and the fourth is eight wake-up lines, and both of these fire only on a falling edge.

Software clears flags by writing ones to a clear port. The controller clears a flag by acknowledging its index. A sense-configuration write port holds the edge choice for the non-maskable line and the 2-bit sense codes for the general lines. The result is a flat vector of 41 pending bits. Arbitration, masking and vector generation happen downstream.

Top module: `irq_sense_unit`

## Requirements
- R1: A synchronous reset clears every pending bit. It selects falling-edge sensing for the non-maskable line and sense code 01 for every general line. The synchroniser stages reset to 1, because pins are idle high.
- R2: The non-maskable line flags on a falling edge when its select bit is 0, and on a rising edge when the bit is 1.
- R3: General line g takes the 2-bit code cfg_gen_sense[2g+1:2g], where 01 means falling edge, 10 means rising edge and 11 means either edge. A matching edge sets the flag and any other edge does not.
- R4: With code 00, the general line's pending bit is the inverse of its synchronised pin. It is not latched, and a clear or an acknowledge does not change it.
- R5: A keypad line sets its flag on a falling edge only. A rising edge leaves the flag at 0.
- R6: A wake-up line sets its flag on a falling edge only. A rising edge leaves the flag at 0.
- R7: An edge-sensed flag stays at 1 until it is cleared.
- R8: When clr_we is 1, every pending bit whose clr_mask bit is 1 goes to 0 on the next clock. Bits whose mask bit is 0 are unchanged. When clr_we is 0, the mask has no effect.
- R9: When ack_valid is 1, the flag at index ack_id goes to 0 on the next clock. No other flag changes.
- R10: If a clear or an acknowledge lands in the same cycle as a new qualifying edge on that line, the flag stays at 1.
- R11: An edge-sensed flag first reads 1 after the third rising clock edge that samples the changed pin. A level-sensed bit follows the pin after the second such edge.
- R12: The pending vector is laid out as follows: bit 0 is the non-maskable line, bits 16:1 are general lines 15:0, bits 32:17 are keypad lines 15:0, and bits 40:33 are wake-up lines 7:0. ack_id and clr_mask use the same indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Raw non-maskable request pin |
| gen_pin | input | 16 | Raw general request pins |
| key_pin | input | 16 | Raw keypad pins |
| wake_pin | input | 8 | Raw wake-up pins |
| cfg_we | input | 1 | Loads both sense settings |
| cfg_nmi_rise | input | 1 | 1 selects rising edge for the non-maskable line |
| cfg_gen_sense | input | 32 | 2-bit sense code per general line |
| clr_we | input | 1 | Enables the write-one-to-clear mask |
| clr_mask | input | 41 | Bits to clear, pending-vector layout |
| ack_valid | input | 1 | Controller acknowledge strobe |
| ack_id | input | 6 | Index of the acknowledged source |
| pending | output | 41 | Pending request vector |

## Verification
Some rules are checked by assertions on every cycle: a detected edge always shows up as a flag on the next cycle, a cleared or acknowledged flag with no competing edge drops, a flag never drops on its own for the fixed-edge classes, and reset leaves the vector empty. Other behaviour needs the bench's directed scenarios. These cover the per-line sense codes, the rising-versus-falling choice on the non-maskable line, level sensing that ignores clears, the exact three-cycle and two-cycle latencies, and a clear that collides with a fresh edge.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_t;

    localparam logic [1:0] GEN_SENSE_DEFAULT = SENSE_FALL;

    // Edge qualification from the previous and current synchronised samples
    function automatic logic edge_hit(input sense_t mode, input logic prv, input logic cur);
        logic fell;
        logic rose;
        fell = prv & ~cur;
        rose = ~prv & cur;
        case (mode)
            SENSE_FALL: edge_hit = fell;
            SENSE_RISE: edge_hit = rose;
            SENSE_BOTH: edge_hit = fell | rose;
            default:    edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
    parameter int   W       = 8,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prv
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= {W{RST_VAL}};
            cur    <= {W{RST_VAL}};
            prv    <= {W{RST_VAL}};
        end else begin
            stage1 <= din;
            cur    <= stage1;
            prv    <= cur;
        end
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    // Set dominates clear so that a fresh event is never dropped
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
    import irq_sense_pkg::*;
#(
    parameter int GEN_N  = 16,
    parameter int KEY_N  = 16,
    parameter int WAKE_N = 8,
    localparam int TOTAL  = 1 + GEN_N + KEY_N + WAKE_N,
    localparam int ID_W   = $clog2(TOTAL),
    localparam int GEN_LO = 1,
    localparam int FIX_LO = 1 + GEN_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_pin,
    input  logic [GEN_N-1:0]   gen_pin,
    input  logic [KEY_N-1:0]   key_pin,
    input  logic [WAKE_N-1:0]  wake_pin,
    input  logic               cfg_we,
    input  logic               cfg_nmi_rise,
    input  logic [2*GEN_N-1:0] cfg_gen_sense,
    input  logic               clr_we,
    input  logic [TOTAL-1:0]   clr_mask,
    input  logic               ack_valid,
    input  logic [ID_W-1:0]    ack_id,
    output logic [TOTAL-1:0]   pending
);
    logic [TOTAL-1:0]   raw;
    logic [TOTAL-1:0]   cur;
    logic [TOTAL-1:0]   prv;
    logic [TOTAL-1:0]   evt;
    logic [TOTAL-1:0]   lvl_mask;
    logic [TOTAL-1:0]   lvl_req;
    logic [TOTAL-1:0]   ack_dec;
    logic [TOTAL-1:0]   clr_vec;
    logic [TOTAL-1:0]   flags;
    logic               nmi_rise_q;
    logic [2*GEN_N-1:0] gen_sense_q;

    assign raw = {wake_pin, key_pin, gen_pin, nmi_pin};

    irq_sync_bank #(.W(TOTAL), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .cur (cur),
        .prv (prv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_rise_q  <= 1'b0;
            gen_sense_q <= {GEN_N{GEN_SENSE_DEFAULT}};
        end else if (cfg_we) begin
            nmi_rise_q  <= cfg_nmi_rise;
            gen_sense_q <= cfg_gen_sense;
        end
    end

    // Non-maskable line: two-way edge choice
    assign evt[0]      = edge_hit(nmi_rise_q ? SENSE_RISE : SENSE_FALL, prv[0], cur[0]);
    assign lvl_mask[0] = 1'b0;
    assign lvl_req[0]  = 1'b0;

    // General lines: per-line four-way sense code
    for (genvar g = 0; g < GEN_N; g++) begin : g_gen
        sense_t mode;
        assign mode                 = sense_t'(gen_sense_q[2*g +: 2]);
        assign evt[GEN_LO+g]        = edge_hit(mode, prv[GEN_LO+g], cur[GEN_LO+g]);
        assign lvl_mask[GEN_LO+g]   = (mode == SENSE_LOW);
        assign lvl_req[GEN_LO+g]    = ~cur[GEN_LO+g];
    end

    // Keypad and wake-up lines: falling edge only
    for (genvar f = FIX_LO; f < TOTAL; f++) begin : g_fix
        assign evt[f]      = edge_hit(SENSE_FALL, prv[f], cur[f]);
        assign lvl_mask[f] = 1'b0;
        assign lvl_req[f]  = 1'b0;
    end

    for (genvar i = 0; i < TOTAL; i++) begin : g_ack
        assign ack_dec[i] = ack_valid && (ack_id == ID_W'(i));
    end

    // Level-sensed lines keep their flag register empty
    assign clr_vec = (clr_we ? clr_mask : '0) | ack_dec | lvl_mask;

    irq_flag_bank #(.W(TOTAL)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (evt),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    assign pending = (flags & ~lvl_mask) | (lvl_req & lvl_mask);

endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk #(
    parameter int TOTAL  = 41,
    parameter int ID_W   = 6,
    parameter int FIX_LO = 17
) (
    input logic             clk,
    input logic             rst,
    input logic [TOTAL-1:0] pending,
    input logic [TOTAL-1:0] evt,
    input logic             clr_we,
    input logic [TOTAL-1:0] clr_mask,
    input logic             ack_valid,
    input logic [ID_W-1:0]  ack_id
);
    logic [TOTAL-1:0] fx;
    logic [TOTAL-1:0] clrv;
    logic [TOTAL-1:0] kill;

    // Bits that are always edge-sensed: non-maskable, keypad, wake-up
    assign fx = ({TOTAL{1'b1}} << FIX_LO) | TOTAL'(1);

    always_comb begin
        clrv = clr_we ? clr_mask : '0;
        if (ack_valid) clrv = clrv | (TOTAL'(1) << ack_id);
    end
    assign kill = clrv & ~evt;

    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (pending == '0));

    p_event_latches_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(evt) & fx & ~pending) == '0));

    p_clear_drops_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(kill) & fx & pending) == '0));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(pending) & ~$past(clrv) & fx & ~pending) == '0));

endmodule

bind irq_sense_unit irq_sense_chk #(
    .TOTAL  (TOTAL),
    .ID_W   (ID_W),
    .FIX_LO (FIX_LO)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pending   (pending),
    .evt       (evt),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .ack_valid (ack_valid),
    .ack_id    (ack_id)
);

// File: tb/test_irq_sense_unit.sv
module test_irq_sense_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_pin = 1'b1;
    logic [15:0] gen_pin = '1;
    logic [15:0] key_pin = '1;
    logic [7:0]  wake_pin = '1;
    logic        cfg_we = 1'b0;
    logic        cfg_nmi_rise = 1'b0;
    logic [31:0] cfg_gen_sense = 32'h5555_5555;
    logic        clr_we = 1'b0;
    logic [40:0] clr_mask = '0;
    logic        ack_valid = 1'b0;
    logic [5:0]  ack_id = '0;
    logic [40:0] pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] gen_cfg = 32'h5555_5555;

    always #2.5 clk = ~clk;

    irq_sense_unit i_irq_sense_unit (
        .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .gen_pin(gen_pin),
        .key_pin(key_pin), .wake_pin(wake_pin), .cfg_we(cfg_we),
        .cfg_nmi_rise(cfg_nmi_rise), .cfg_gen_sense(cfg_gen_sense),
        .clr_we(clr_we), .clr_mask(clr_mask), .ack_valid(ack_valid),
        .ack_id(ack_id), .pending(pending)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_bit(input int idx, input logic exp, input string req);
        checks++;
        if (pending[idx] !== exp) begin
            errors++;
            $display("FAIL %s: pending[%0d] actual %b expected %b", req, idx, pending[idx], exp);
        end
    endtask

    task automatic chk_vec(input logic [40:0] exp, input string req);
        checks++;
        if (pending !== exp) begin
            errors++;
            $display("FAIL %s: pending actual %h expected %h", req, pending, exp);
        end
    endtask

    task automatic wr_cfg(input logic nr);
        cfg_nmi_rise = nr; cfg_gen_sense = gen_cfg; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic clr_bits(input logic [40:0] m);
        clr_mask = m; clr_we = 1'b1;
        step(1);
        clr_we = 1'b0; clr_mask = '0;
    endtask

    task automatic ack(input int id);
        ack_id = 6'(id); ack_valid = 1'b1;
        step(1);
        ack_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk_vec('0, "R1 reset empty");
        gen_pin[3] = 1'b0; step(3);
        chk_bit(4, 1'b1, "R1 default falling sense");
        gen_pin[3] = 1'b1; step(3);
        clr_bits(41'd1 << 4);
        chk_bit(4, 1'b0, "R8 cleared");
    endtask

    task automatic t_latency;
        key_pin[5] = 1'b0; step(2);
        chk_bit(22, 1'b0, "R11 not yet after two edges");
        step(1);
        chk_bit(22, 1'b1, "R11 set after third edge");
        key_pin[5] = 1'b1; step(3);
        clr_bits(41'd1 << 22);
    endtask

    task automatic t_nmi;
        nmi_pin = 1'b0; step(3);
        chk_bit(0, 1'b1, "R2 falling edge default");
        nmi_pin = 1'b1; step(3);
        clr_bits(41'd1);
        chk_bit(0, 1'b0, "R2 rising ignored in falling mode");
        wr_cfg(1'b1);
        nmi_pin = 1'b0; step(3);
        chk_bit(0, 1'b0, "R2 falling ignored in rising mode");
        nmi_pin = 1'b1; step(3);
        chk_bit(0, 1'b1, "R2 rising edge selected");
        clr_bits(41'd1);
        wr_cfg(1'b0);
    endtask

    task automatic t_gen_modes;
        gen_cfg[11:10] = 2'b10; gen_cfg[13:12] = 2'b11;
        wr_cfg(1'b0);
        gen_pin[5] = 1'b0; step(3);
        chk_bit(6, 1'b0, "R3 rising mode ignores fall");
        gen_pin[5] = 1'b1; step(3);
        chk_bit(6, 1'b1, "R3 rising mode sets");
        gen_pin[6] = 1'b0; step(3);
        chk_bit(7, 1'b1, "R3 both mode falling");
        clr_bits(41'd1 << 7);
        chk_bit(7, 1'b0, "R8 clear both-mode flag");
        gen_pin[6] = 1'b1; step(3);
        chk_bit(7, 1'b1, "R3 both mode rising");
        clr_bits((41'd1 << 7) | (41'd1 << 6));
    endtask

    task automatic t_level;
        gen_cfg[15:14] = 2'b00;
        wr_cfg(1'b0);
        chk_bit(8, 1'b0, "R4 level idle high");
        gen_pin[7] = 1'b0; step(1);
        chk_bit(8, 1'b0, "R11 level after one edge");
        step(1);
        chk_bit(8, 1'b1, "R4 R11 level follows after two edges");
        clr_bits(41'd1 << 8);
        chk_bit(8, 1'b1, "R4 clear has no effect on level");
        ack(8);
        chk_bit(8, 1'b1, "R4 ack has no effect on level");
        gen_pin[7] = 1'b1; step(2);
        chk_bit(8, 1'b0, "R4 level released");
    endtask

    task automatic t_key;
        key_pin[2] = 1'b0; step(3);
        chk_bit(19, 1'b1, "R5 keypad falling");
        clr_bits(41'd1 << 19);
        key_pin[2] = 1'b1; step(3);
        chk_bit(19, 1'b0, "R5 keypad rising ignored");
    endtask

    task automatic t_wake;
        wake_pin[7] = 1'b0; step(3);
        chk_vec(41'd1 << 40, "R6 R12 wake line 7 at bit 40");
        clr_bits(41'd1 << 40);
        wake_pin[7] = 1'b1; step(3);
        chk_bit(40, 1'b0, "R6 wake rising ignored");
    endtask

    task automatic t_sticky;
        wake_pin[2] = 1'b0; step(3);
        wake_pin[2] = 1'b1; step(20);
        chk_bit(35, 1'b1, "R7 flag held until cleared");
        clr_bits(41'd1 << 35);
    endtask

    task automatic t_clear;
        key_pin[0] = 1'b0; key_pin[1] = 1'b0; wake_pin[0] = 1'b0;
        step(3);
        clr_bits((41'd1 << 17) | (41'd1 << 33));
        chk_vec(41'd1 << 18, "R8 only masked bits cleared");
        clr_mask = 41'd1 << 18; step(1); clr_mask = '0;
        chk_bit(18, 1'b1, "R8 mask ignored without strobe");
        key_pin[0] = 1'b1; key_pin[1] = 1'b1; wake_pin[0] = 1'b1;
        step(3);
    endtask

    task automatic t_ack;
        wake_pin[1] = 1'b0; step(3);
        ack(18);
        chk_vec(41'd1 << 34, "R9 ack clears only its index");
        ack(34);
        chk_bit(34, 1'b0, "R9 ack clears wake flag");
        wake_pin[1] = 1'b1; step(3);
    endtask

    task automatic t_collide;
        key_pin[3] = 1'b0; step(3);
        key_pin[3] = 1'b1; step(3);
        key_pin[3] = 1'b0; step(2);
        clr_bits(41'd1 << 20);
        chk_bit(20, 1'b1, "R10 clear with new edge keeps flag");
        key_pin[3] = 1'b1; step(2);
        key_pin[3] = 1'b0; step(2);
        ack(20);
        chk_bit(20, 1'b1, "R10 ack with new edge keeps flag");
        clr_bits(41'd1 << 20);
        chk_bit(20, 1'b0, "R8 clear after collision");
        key_pin[3] = 1'b1; step(3);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        step(4);
        rst = 1'b0;
        step(2);
        t_reset();
        t_latency();
        t_nmi();
        t_gen_modes();
        t_level();
        t_key();
        t_wake();
        t_sticky();
        t_clear();
        t_ack();
        t_collide();
        chk_vec('0, "R8 all flags cleared at end");
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule